// File: doc/BRIEF.md
# Dual-Mode Reference and Feedback Divider Core

This block is the counting heart of a frequency-synthesiser tuning loop. Two divider chains run side by side, each on its own clock. The reference chain divides a nominal 4 MHz crystal clock down to the comparison rate. It divides by 512 (7.8125 kHz) when the step select is high and by 640 (6.25 kHz) when it is low. The feedback chain divides the already prescaled RF clock (RF/8) by a programmable divisor. Because of the fixed divide-by-8 ahead of it, one divisor count is worth eight comparison periods of LO frequency: 62.5 kHz per step in the high mode and 50 kHz per step in the low mode.

In the high mode the top bit of the 15-bit divisor is bypassed, so only the lower 14 bits set the ratio. In the low mode all 15 bits are used. Each chain emits a one-cycle pulse per period for a phase/frequency comparator in its own domain. It also emits a level that flips once per pulse, so that the event can be carried safely into another clock domain. A new divisor or mode is picked up only at a chain's terminal count. A division period in progress therefore always completes with the ratio it started with. This makes fine-tuning updates glitch-free.

Both chains use the same three-state counter machine. LOAD is entered from reset; it captures the ratio and moves to COUNT. COUNT decrements the counter and stays in COUNT while the counter is above 1, then moves to TERM when the counter reaches 1. TERM is the one-cycle pulse state; it reloads the counter with the current ratio minus one and returns to COUNT. The period is therefore exactly the ratio in clock cycles.

Top module: `pll_div_core`

## Requirements
- R1: While a domain's reset is low, that domain's pulse output and toggle output are both 0.
- R2: With step_sel = 1, fcomp_pulse occurs once every 512 ref_clk cycles.
- R3: With step_sel = 0, fcomp_pulse occurs once every 640 ref_clk cycles.
- R4: With step_sel = 1, the feedback period in rf_clk cycles equals divisor[13:0]; divisor bit 14 has no effect.
- R5: With step_sel = 0, the feedback period in rf_clk cycles equals the full divisor[14:0].
- R6: An effective divisor of 0 or 1 gives a feedback period of 2 rf_clk cycles.
- R7: divisor and step_sel are sampled only on the clock edge that ends a pulse cycle (and on the first edge after reset). A change at any other time leaves the current period unchanged and takes effect for the following period.
- R8: fpd_pulse and fcomp_pulse are never high on two consecutive cycles of their own clock.
- R9: Each toggle output changes exactly once per pulse of its chain, on the edge that ends the pulse cycle, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Crystal reference clock (nominally 4 MHz) |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| rf_clk | input | 1 | Prescaled RF clock (RF/8) |
| rf_rst_n | input | 1 | Active-low asynchronous reset, RF domain |
| step_sel | input | 1 | 1: ratio 512, 14-bit divisor; 0: ratio 640, 15-bit divisor |
| divisor | input | 15 | Latched divisor word from the serial loader |
| fcomp_pulse | output | 1 | One-cycle comparison pulse, ref_clk domain |
| fcomp_toggle | output | 1 | Flips once per fcomp_pulse |
| fpd_pulse | output | 1 | One-cycle feedback pulse, rf_clk domain |
| fpd_toggle | output | 1 | Flips once per fpd_pulse |

## Verification
The bench measures every feedback period against a scoreboard and targets several corner cases. A divisor with bit 14 set is used in both modes; a design that fails to bypass that bit in the high mode would produce a period near 16k cycles instead of 3. Divisors of 0 and 1 are used in both modes, including 0x4001 in the high mode, which reduces to 1 after masking; a design without the clamp would stall or emit a pulse every cycle. The divisor is also changed four cycles into a period; a design that reloads mid-count would shorten that period. The reference periods are checked in both modes, and a missing or doubled toggle flip is reported between any two pulses.

// File: rtl/pll_div_pkg.sv
`timescale 1ns/1ps
package pll_div_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_TERM  = 2'd2
    } div_state_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fb_ratio_sel.sv
`timescale 1ns/1ps
module fb_ratio_sel #(
    parameter int DIV_W     = 15,
    parameter int NARROW_W  = 14,
    parameter int MIN_RATIO = 2
) (
    input  logic             step_sel,
    input  logic [DIV_W-1:0] divisor,
    output logic [DIV_W-1:0] ratio
);
    localparam logic [DIV_W-1:0] MIN_VAL = DIV_W'(MIN_RATIO);

    logic [DIV_W-1:0] masked;

    generate
        if (NARROW_W < DIV_W) begin : g_bypass
            logic [DIV_W-1:0] narrow;
            assign narrow = {{(DIV_W-NARROW_W){1'b0}}, divisor[NARROW_W-1:0]};
            assign masked = step_sel ? narrow : divisor;
        end else begin : g_full
            logic unused_sel;
            assign unused_sel = step_sel;
            assign masked     = divisor;
        end
    endgenerate

    always_comb begin
        ratio = (masked < MIN_VAL) ? MIN_VAL : masked;
    end

endmodule

// File: rtl/div_fsm.sv
`timescale 1ns/1ps
module div_fsm #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    import pll_div_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    div_state_t state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_LOAD: begin
                cnt_d   = ratio - ONE;
                state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (cnt_q <= ONE) begin
                    state_d = ST_TERM;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            ST_TERM: begin
                cnt_d   = ratio - ONE;
                state_d = ST_COUNT;
            end
            default: begin
                state_d = ST_LOAD;
            end
        endcase
    end

    // outputs
    always_comb begin
        pulse = (state_q == ST_TERM);
    end

endmodule

// File: rtl/pulse_toggle.sv
`timescale 1ns/1ps
module pulse_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic toggle
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toggle <= 1'b0;
        end else if (pulse) begin
            toggle <= ~toggle;
        end
    end
endmodule

// File: rtl/pll_div_core.sv
`timescale 1ns/1ps
module pll_div_core #(
    parameter int DIV_W       = 15,
    parameter int NARROW_W    = 14,
    parameter int REF_RATIO_A = 512,
    parameter int REF_RATIO_B = 640,
    parameter int MIN_RATIO   = 2
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             rf_clk,
    input  logic             rf_rst_n,
    input  logic             step_sel,
    input  logic [DIV_W-1:0] divisor,
    output logic             fcomp_pulse,
    output logic             fcomp_toggle,
    output logic             fpd_pulse,
    output logic             fpd_toggle
);
    import pll_div_pkg::*;

    localparam int REF_MAX = int'(max2(REF_RATIO_A, REF_RATIO_B));
    localparam int REF_W   = $clog2(REF_MAX + 1);

    logic [REF_W-1:0] ref_ratio;
    logic [DIV_W-1:0] fb_ratio;

    assign ref_ratio = step_sel ? REF_W'(REF_RATIO_A) : REF_W'(REF_RATIO_B);

    div_fsm #(.W(REF_W)) u_ref_div (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .ratio (ref_ratio),
        .pulse (fcomp_pulse)
    );

    pulse_toggle u_ref_tog (
        .clk    (ref_clk),
        .rst_n  (ref_rst_n),
        .pulse  (fcomp_pulse),
        .toggle (fcomp_toggle)
    );

    fb_ratio_sel #(
        .DIV_W     (DIV_W),
        .NARROW_W  (NARROW_W),
        .MIN_RATIO (MIN_RATIO)
    ) u_fb_sel (
        .step_sel (step_sel),
        .divisor  (divisor),
        .ratio    (fb_ratio)
    );

    div_fsm #(.W(DIV_W)) u_fb_div (
        .clk   (rf_clk),
        .rst_n (rf_rst_n),
        .ratio (fb_ratio),
        .pulse (fpd_pulse)
    );

    pulse_toggle u_fb_tog (
        .clk    (rf_clk),
        .rst_n  (rf_rst_n),
        .pulse  (fpd_pulse),
        .toggle (fpd_toggle)
    );

endmodule

// File: rtl/pll_div_core_chk.sv
`timescale 1ns/1ps
module pll_div_core_chk #(
    parameter int REF_RATIO_A = 512,
    parameter int REF_RATIO_B = 640
) (
    input logic ref_clk,
    input logic ref_rst_n,
    input logic rf_clk,
    input logic rf_rst_n,
    input logic fcomp_pulse,
    input logic fcomp_toggle,
    input logic fpd_pulse,
    input logic fpd_toggle
);
    localparam int GAP_MAX = (REF_RATIO_A > REF_RATIO_B) ? REF_RATIO_A : REF_RATIO_B;
    localparam int GW      = $clog2(GAP_MAX) + 2;

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (fcomp_pulse) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != {GW{1'b1}}) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2 / R3: spacing of comparison pulses matches one of the two ratios
    p_fcomp_ratio_r2: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (fcomp_pulse && seen_q) |-> (gap_q == GW'(REF_RATIO_A - 1) || gap_q == GW'(REF_RATIO_B - 1)));

    p_fcomp_single_r8: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        fcomp_pulse |=> !fcomp_pulse);

    // also covers the minimum ratio of R6
    p_fpd_single_r8: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
        fpd_pulse |=> !fpd_pulse);

    p_fpd_flip_r9: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
        fpd_pulse |=> (fpd_toggle != $past(fpd_toggle)));

    p_fpd_hold_r9: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
        !fpd_pulse |=> $stable(fpd_toggle));

    p_fcomp_flip_r9: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        fcomp_pulse |=> (fcomp_toggle != $past(fcomp_toggle)));

    p_fcomp_hold_r9: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !fcomp_pulse |=> $stable(fcomp_toggle));

    always @(posedge rf_clk) begin
        if (!rf_rst_n) begin
            p_fpd_idle_r1: assert (!fpd_pulse && !fpd_toggle);
        end
    end

    always @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            p_fcomp_idle_r1: assert (!fcomp_pulse && !fcomp_toggle);
        end
    end

endmodule

bind pll_div_core pll_div_core_chk #(
    .REF_RATIO_A (REF_RATIO_A),
    .REF_RATIO_B (REF_RATIO_B)
) u_chk (
    .ref_clk      (ref_clk),
    .ref_rst_n    (ref_rst_n),
    .rf_clk       (rf_clk),
    .rf_rst_n     (rf_rst_n),
    .fcomp_pulse  (fcomp_pulse),
    .fcomp_toggle (fcomp_toggle),
    .fpd_pulse    (fpd_pulse),
    .fpd_toggle   (fpd_toggle)
);

// File: tb/sim_pll_div_core.sv
`timescale 1ns/1ps
module sim_pll_div_core;

    logic        ref_clk = 1'b0;
    logic        rf_clk  = 1'b0;
    logic        ref_rst_n = 1'b0;
    logic        rf_rst_n  = 1'b0;
    logic        step_sel  = 1'b1;
    logic [14:0] divisor   = 15'd20;
    logic        fcomp_pulse, fcomp_toggle, fpd_pulse, fpd_toggle;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int    fb_exp_q[$];
    string fb_tag_q[$];
    int    ref_exp_q[$];
    string ref_tag_q[$];

    always #10 ref_clk = ~ref_clk;   // 50 MHz
    always #7  rf_clk  = ~rf_clk;

    pll_div_core u0 (
        .ref_clk      (ref_clk),
        .ref_rst_n    (ref_rst_n),
        .rf_clk       (rf_clk),
        .rf_rst_n     (rf_rst_n),
        .step_sel     (step_sel),
        .divisor      (divisor),
        .fcomp_pulse  (fcomp_pulse),
        .fcomp_toggle (fcomp_toggle),
        .fpd_pulse    (fpd_pulse),
        .fpd_toggle   (fpd_toggle)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_fb(input logic [14:0] d, input logic sel);
        int m;
        m = sel ? int'(d[13:0]) : int'(d);
        return (m < 2) ? 2 : m;
    endfunction

    // ---------------- RF domain monitor ----------------
    int rf_cyc = 0, rf_last = 0, rf_flips = 0;
    bit rf_have = 1'b0;
    logic rf_prev_tog = 1'b0;

    always @(negedge rf_clk) begin
        rf_cyc++;
        if (rf_rst_n) begin
            if (fpd_toggle != rf_prev_tog) rf_flips++;
            rf_prev_tog = fpd_toggle;
            if (fpd_pulse) begin
                if (rf_have) begin
                    check(rf_flips == 1, "R9 fpd toggle flips", rf_flips, 1);
                    if (fb_exp_q.size() > 0) begin
                        int e;
                        string t;
                        e = fb_exp_q.pop_front();
                        t = fb_tag_q.pop_front();
                        check(rf_cyc - rf_last == e, t, rf_cyc - rf_last, e);
                    end
                end
                rf_have  = 1'b1;
                rf_last  = rf_cyc;
                rf_flips = 0;
            end
        end
    end

    // ---------------- REF domain monitor and predictor ----------------
    int ref_cyc = 0, ref_last = 0, ref_flips = 0;
    bit ref_have = 1'b0;
    logic ref_prev_tog = 1'b0;

    always @(negedge ref_clk) begin
        ref_cyc++;
        if (ref_rst_n) begin
            if (fcomp_toggle != ref_prev_tog) ref_flips++;
            ref_prev_tog = fcomp_toggle;
            if (fcomp_pulse) begin
                if (ref_have) begin
                    check(ref_flips == 1, "R9 fcomp toggle flips", ref_flips, 1);
                    if (ref_exp_q.size() > 0) begin
                        int e;
                        string t;
                        e = ref_exp_q.pop_front();
                        t = ref_tag_q.pop_front();
                        if (e != 0) check(ref_cyc - ref_last == e, t, ref_cyc - ref_last, e);
                    end
                end
                ref_have  = 1'b1;
                ref_last  = ref_cyc;
                ref_flips = 0;
            end
        end
    end

    // predictor: mode is sampled at the edge ending the pulse cycle (R7)
    initial begin
        forever begin
            logic m0, m1;
            @(negedge ref_clk);
            if (ref_rst_n && fcomp_pulse) begin
                m0 = step_sel;
                @(posedge ref_clk);
                m1 = step_sel;
                if (m0 != m1) begin
                    ref_exp_q.push_back(0);
                    ref_tag_q.push_back("skip");
                end else begin
                    ref_exp_q.push_back(m1 ? 512 : 640);
                    ref_tag_q.push_back(m1 ? "R2 ref period" : "R3 ref period");
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic wait_fpd();
        do @(negedge rf_clk); while (!fpd_pulse);
    endtask

    task automatic next_period(input logic [14:0] d, input logic sel, input string tag);
        wait_fpd();
        #2;
        divisor  = d;
        step_sel = sel;
        fb_exp_q.push_back(model_fb(d, sel));
        fb_tag_q.push_back(tag);
    endtask

    task automatic wait_fcomp();
        do @(negedge ref_clk); while (!fcomp_pulse);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge ref_clk);
        check(fcomp_pulse == 1'b0, "R1 fcomp_pulse in reset", fcomp_pulse, 0);
        check(fcomp_toggle == 1'b0, "R1 fcomp_toggle in reset", fcomp_toggle, 0);
        @(negedge rf_clk);
        check(fpd_pulse == 1'b0, "R1 fpd_pulse in reset", fpd_pulse, 0);
        check(fpd_toggle == 1'b0, "R1 fpd_toggle in reset", fpd_toggle, 0);
        @(negedge rf_clk) rf_rst_n = 1'b1;
        @(negedge ref_clk) ref_rst_n = 1'b1;

        // R4: 14-bit divisor in the 512 mode
        repeat (3) next_period(15'd20, 1'b1, "R4 period div 20");
        repeat (2) next_period(15'h4003, 1'b1, "R4 bit14 ignored");
        // R5: full divisor in the 640 mode
        next_period(15'h4003, 1'b0, "R5 period 16387");
        repeat (2) next_period(15'd700, 1'b0, "R5 period 700");
        // R6: clamp
        next_period(15'd0, 1'b0, "R6 div 0");
        next_period(15'd1, 1'b0, "R6 div 1");
        next_period(15'd0, 1'b1, "R6 div 0 narrow");
        next_period(15'h4001, 1'b1, "R6 masked to 1");
        next_period(15'd2, 1'b0, "R6 div 2");
        next_period(15'd3, 1'b0, "R6 div 3");
        // R7: change mid-period
        next_period(15'd12, 1'b1, "R7 before change");
        wait_fpd();
        #2;
        fb_exp_q.push_back(12);
        fb_tag_q.push_back("R7 mid-count change ignored");
        repeat (4) @(negedge rf_clk);
        divisor = 15'd5;
        next_period(15'd5, 1'b1, "R7 new value next period");
        wait_fpd();
        @(negedge rf_clk);
        check(fb_exp_q.size() == 0, "R7 scoreboard drained", fb_exp_q.size(), 0);

        // extra reference periods in the 512 mode (R2)
        step_sel = 1'b1;
        repeat (4) wait_fcomp();
        @(negedge ref_clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule